// File: doc/BRIEF.md
# Fuse Macro Word Read Sequencer

This block reads a run of consecutive 32-bit words out of a one-time-programmable fuse macro. It drives the macro's raw control pins directly, replacing the slow register-level pin toggling that software would otherwise do. A requester gives a start strobe, a first word index and a word count. The sequencer checks that the run fits inside the array. It then wakes the macro in a fixed pin order and, for each word, presents the address and pulses the macro clock with fixed high and low dwell times. It samples the data bus and hands the word back with a valid strobe. Finally it puts the macro back to sleep in the reverse pin order.

The word index is the byte offset divided by four. The array size, the data width and both dwell times are parameters. A run that does not fit is refused at once with an error pulse, and no macro pin moves. A run of zero words still wakes the macro and puts it back to sleep, then reports completion.

Top module: `otp_rd_seq`

## Requirements
- R1: After reset, all macro pins (standby release, trim, enable, clock, address) are 0, and `busy`, `rsp_valid`, `req_done` and `req_err` are 0.
- R2: A start with `req_index >= FUSES` or `req_index + req_count > FUSES` raises `req_err` for exactly the cycle after the start edge. No macro pin changes, and `busy` stays 0.
- R3: An accepted start raises `otp_dstb_n` (active low: 1 means out of deep standby) in the cycle after the start edge. `otp_trim` rises one cycle later and `otp_ce` one cycle after that.
- R4: For word j, the address register loads `req_index + j` as the word's step begins. One cycle later `otp_clk` goes high for HI_CYC cycles, then low for LO_CYC cycles. The address does not change while the clock is high.
- R5: When the low phase ends, the sequencer captures `otp_dout` into `rsp_data` and pulses `rsp_valid` for one cycle. One word step takes 1+HI_CYC+LO_CYC cycles.
- R6: Exactly `req_count` beats are produced, at ascending addresses starting at `req_index`.
- R7: After the last beat, `otp_ce` falls, then `otp_trim`, then `otp_dstb_n`, one cycle apart. `req_done` pulses in the same cycle that `otp_dstb_n` is low again.
- R8: An accepted request with `req_count = 0` runs the power-up and shutdown only. It pulses `req_done` six cycles after the start edge, and `otp_clk` and `rsp_valid` never go high.
- R9: `busy` is high from the cycle after an accepted start until `req_done` rises. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe |
| req_index | input | IDXW | First word index of the run |
| req_count | input | CNTW | Number of words to read |
| rsp_valid | output | 1 | One-cycle strobe marking a returned word |
| rsp_data | output | DW | Returned word |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | Sequence in progress |
| otp_dstb_n | output | 1 | Deep-standby pin, active low |
| otp_trim | output | 1 | Trim enable pin |
| otp_ce | output | 1 | Macro enable pin |
| otp_addr | output | AW | Macro word address |
| otp_clk | output | 1 | Macro clock, pulsed by the sequencer |
| otp_dout | input | DW | Macro read data |

## Verification
The assertions assume that `otp_dout` is steady for the whole word step, because it is a pure function of the held address. They also assume that `req_start` is a single-cycle pulse whose index and count are valid in the same cycle. The bench fuse model derives each word combinationally from `otp_addr`. The bench drives the strobe and its operands only on falling edges, for one cycle each. When it injects an extra strobe during a run, it does so only while `busy` is already high.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PU_TRIM,
    ST_PU_CE,
    ST_ADDR,
    ST_HI,
    ST_LO,
    ST_PD_CE,
    ST_PD_TRIM,
    ST_PD_DSTB
  } seq_state_e;

  // A run fits when its first word lies inside and its end does not pass the limit.
  function automatic logic span_fits(input int unsigned first,
                                     input int unsigned n,
                                     input int unsigned limit);
    return (first < limit) && ((first + n) <= limit);
  endfunction

  // Cycles one word occupies: address step, clock high, clock low.
  function automatic int unsigned beat_period(input int unsigned hi,
                                              input int unsigned lo);
    return 1 + hi + lo;
  endfunction

endpackage

// File: rtl/otp_rd_range.sv
module otp_rd_range #(
  parameter int FUSES = 4096,
  parameter int IDXW  = 13,
  parameter int CNTW  = 13
) (
  input  logic [IDXW-1:0] idx,
  input  logic [CNTW-1:0] cnt,
  output logic            ok
);
  import otp_rd_pkg::*;

  always_comb begin
    ok = span_fits(32'(idx), 32'(cnt), 32'(FUSES));
  end

endmodule

// File: rtl/otp_rd_dwell.sv
module otp_rd_dwell #(
  parameter int HI_CYC = 2,
  parameter int LO_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_hi,
  input  logic load_lo,
  output logic expired
);
  localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int TW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  logic [TW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (load_hi)        left <= TW'(HI_CYC - 1);
    else if (load_lo)        left <= TW'(LO_CYC - 1);
    else if (left != '0)     left <= left - TW'(1);
  end

  assign expired = (left == '0);

  // R4: the two phase loads come from distinct states and never coincide
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_hi && load_lo));

  // R4: a loaded phase counts down one step per cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hi && !load_lo && left != '0) |=> (left == $past(left) - TW'(1)));

endmodule

// File: rtl/otp_rd_ctrl.sv
module otp_rd_ctrl #(
  parameter int DW   = 32,
  parameter int AW   = 12,
  parameter int IDXW = 13,
  parameter int CNTW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            req_ok,
  input  logic [IDXW-1:0] req_idx,
  input  logic [CNTW-1:0] req_cnt,
  input  logic            tmr_expired,
  output logic            tmr_load_hi,
  output logic            tmr_load_lo,
  input  logic [DW-1:0]   otp_dout,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            done,
  output logic            err,
  output logic            busy,
  output logic            otp_dstb_n,
  output logic            otp_trim,
  output logic            otp_ce,
  output logic [AW-1:0]   otp_addr,
  output logic            otp_clk
);
  import otp_rd_pkg::*;

  seq_state_e      state;
  logic [IDXW-1:0] cur_idx;
  logic [CNTW-1:0] left;

  // named events for the assertions
  logic            idle;
  logic            accept;
  logic            reject;
  logic            beat;
  logic            last_beat;
  logic [IDXW-1:0] nxt_idx;

  assign idle      = (state == ST_IDLE);
  assign accept    = idle && start && req_ok;
  assign reject    = idle && start && !req_ok;
  assign beat      = (state == ST_LO) && tmr_expired;
  assign last_beat = beat && (left == CNTW'(1));
  assign nxt_idx   = cur_idx + IDXW'(1);

  assign tmr_load_hi = (state == ST_ADDR);
  assign tmr_load_lo = (state == ST_HI) && tmr_expired;
  assign busy        = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_idx    <= '0;
      left       <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      otp_dstb_n <= 1'b0;
      otp_trim   <= 1'b0;
      otp_ce     <= 1'b0;
      otp_addr   <= '0;
      otp_clk    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            otp_dstb_n <= 1'b1;
            cur_idx    <= req_idx;
            left       <= req_cnt;
            state      <= ST_PU_TRIM;
          end else if (reject) begin
            err <= 1'b1;
          end
        end
        ST_PU_TRIM: begin
          otp_trim <= 1'b1;
          state    <= ST_PU_CE;
        end
        ST_PU_CE: begin
          otp_ce <= 1'b1;
          if (left != '0) begin
            otp_addr <= cur_idx[AW-1:0];
            state    <= ST_ADDR;
          end else begin
            state <= ST_PD_CE;
          end
        end
        ST_ADDR: begin
          otp_clk <= 1'b1;
          state   <= ST_HI;
        end
        ST_HI: begin
          if (tmr_expired) begin
            otp_clk <= 1'b0;
            state   <= ST_LO;
          end
        end
        ST_LO: begin
          if (tmr_expired) begin
            rsp_valid <= 1'b1;
            rsp_data  <= otp_dout;
            left      <= left - CNTW'(1);
            cur_idx   <= nxt_idx;
            if (last_beat) begin
              state <= ST_PD_CE;
            end else begin
              otp_addr <= nxt_idx[AW-1:0];
              state    <= ST_ADDR;
            end
          end
        end
        ST_PD_CE: begin
          otp_ce <= 1'b0;
          state  <= ST_PD_TRIM;
        end
        ST_PD_TRIM: begin
          otp_trim <= 1'b0;
          state    <= ST_PD_DSTB;
        end
        ST_PD_DSTB: begin
          otp_dstb_n <= 1'b0;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: trim only while out of deep standby, enable only while trimmed
  a_r3_trim_needs_dstb: assert property (@(posedge clk) disable iff (!rst_n)
    otp_trim |-> otp_dstb_n);
  a_r3_ce_needs_trim: assert property (@(posedge clk) disable iff (!rst_n)
    otp_ce |-> otp_trim);
  a_r3_trim_after_dstb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_trim) |-> $past(otp_dstb_n));
  a_r3_ce_after_trim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(otp_ce) |-> $past(otp_trim));

  // R4: clock pulses only with the macro enabled, address held under the clock
  a_r4_clk_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    otp_clk |-> otp_ce);
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    otp_clk |-> $stable(otp_addr));

  // R5: a word is handed back only after the clock low phase, macro still on
  a_r5_valid_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!otp_clk && otp_ce && $past(!otp_clk)));

  // R7: trim drops only after enable, standby re-entry coincides with done
  a_r7_trim_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otp_trim) |-> $past(!otp_ce));
  a_r7_dstb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(otp_dstb_n) |-> done);

  // R2: a refused request leaves the macro in deep standby and idle
  a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!otp_dstb_n && !busy && !otp_ce));

  // R9: done closes a busy period, starts while busy leave operands alone
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_LO) |=> $stable(cur_idx));

endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq #(
  parameter int FUSES  = 4096,
  parameter int DW     = 32,
  parameter int HI_CYC = 2,
  parameter int LO_CYC = 2,
  localparam int AW    = $clog2(FUSES),
  localparam int IDXW  = AW + 1,
  localparam int CNTW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [IDXW-1:0] req_index,
  input  logic [CNTW-1:0] req_count,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            req_done,
  output logic            req_err,
  output logic            busy,
  output logic            otp_dstb_n,
  output logic            otp_trim,
  output logic            otp_ce,
  output logic [AW-1:0]   otp_addr,
  output logic            otp_clk,
  input  logic [DW-1:0]   otp_dout
);

  logic span_ok;
  logic tmr_expired;
  logic tmr_load_hi;
  logic tmr_load_lo;

  otp_rd_range #(.FUSES(FUSES), .IDXW(IDXW), .CNTW(CNTW)) u_range (
    .idx (req_index),
    .cnt (req_count),
    .ok  (span_ok)
  );

  otp_rd_dwell #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_dwell (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hi (tmr_load_hi),
    .load_lo (tmr_load_lo),
    .expired (tmr_expired)
  );

  otp_rd_ctrl #(.DW(DW), .AW(AW), .IDXW(IDXW), .CNTW(CNTW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (req_start),
    .req_ok      (span_ok),
    .req_idx     (req_index),
    .req_cnt     (req_count),
    .tmr_expired (tmr_expired),
    .tmr_load_hi (tmr_load_hi),
    .tmr_load_lo (tmr_load_lo),
    .otp_dout    (otp_dout),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .done        (req_done),
    .err         (req_err),
    .busy        (busy),
    .otp_dstb_n  (otp_dstb_n),
    .otp_trim    (otp_trim),
    .otp_ce      (otp_ce),
    .otp_addr    (otp_addr),
    .otp_clk     (otp_clk)
  );

endmodule

// File: tb/tb_otp_rd_seq.sv
module tb_otp_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FUSES      = 4096;
  localparam int HI         = 2;
  localparam int LO         = 3;
  localparam int DW         = 32;
  localparam int AW         = $clog2(FUSES);
  localparam int IDXW       = AW + 1;
  localparam int CNTW       = AW + 1;
  localparam int P          = 1 + HI + LO;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_start = 1'b0;
  logic [IDXW-1:0] req_index = '0;
  logic [CNTW-1:0] req_count = '0;
  logic            rsp_valid, req_done, req_err, busy;
  logic [DW-1:0]   rsp_data, otp_dout;
  logic            otp_dstb_n, otp_trim, otp_ce, otp_clk;
  logic [AW-1:0]   otp_addr;

  int checks = 0;
  int fails  = 0;
  bit reported = 1'b0;

  otp_rd_seq #(.FUSES(FUSES), .DW(DW), .HI_CYC(HI), .LO_CYC(LO)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_index(req_index),
    .req_count(req_count), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .req_done(req_done), .req_err(req_err), .busy(busy),
    .otp_dstb_n(otp_dstb_n), .otp_trim(otp_trim), .otp_ce(otp_ce),
    .otp_addr(otp_addr), .otp_clk(otp_clk), .otp_dout(otp_dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural fuse array: each word is a scrambled copy of its index
  function automatic logic [DW-1:0] fuse_word(input logic [AW-1:0] a);
    return ({{(DW-AW){1'b0}}, a} * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  assign otp_dout = fuse_word(otp_addr);

  function automatic bit fits(input int idx, input int n);
    return (idx < FUSES) && (idx + n <= FUSES);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " busy"}, 32'(busy), 0);
    chk({tag, " pins"}, 32'({otp_dstb_n, otp_trim, otp_ce, otp_clk}), 0);
    chk({tag, " strobes"}, 32'({rsp_valid, req_done, req_err}), 0);
  endtask

  task automatic run_req(input int idx, input int n, input bit inject);
    int last;
    @(negedge clk);
    req_start = 1'b1;
    req_index = IDXW'(idx);
    req_count = CNTW'(n);
    if (!fits(idx, n)) begin
      @(negedge clk);
      req_start = 1'b0;
      chk("R2 err pulse", 32'(req_err), 1);
      chk("R2 busy low", 32'(busy), 0);
      chk("R2 pins untouched", 32'({otp_dstb_n, otp_trim, otp_ce, otp_clk}), 0);
      chk("R2 no beat", 32'(rsp_valid), 0);
      @(negedge clk);
      chk("R2 err one cycle", 32'(req_err), 0);
      return;
    end
    last = 6 + n * P;
    for (int k = 1; k <= last + 2; k++) begin
      bit e_clk, e_valid, in_words;
      int m, ph, j;
      @(negedge clk);
      if (k == 1) req_start = 1'b0;
      if (inject && k == 5) begin
        req_start = 1'b1;
        req_index = IDXW'((idx + 7) % FUSES);
        req_count = CNTW'(2);
      end
      if (inject && k == 6) req_start = 1'b0;
      m = k - 3;
      in_words = (n > 0) && (k >= 3) && (m < n * P);
      ph = (k >= 3) ? (m % P) : 0;
      j  = (k >= 3) ? (m / P) : 0;
      e_clk   = in_words && (ph >= 1) && (ph <= HI);
      e_valid = (n > 0) && (k > 3) && (ph == 0) && (j >= 1) && (j <= n);
      chk("R3 dstb_n released", 32'(otp_dstb_n), 32'(k < last));
      chk("R3 trim", 32'(otp_trim), 32'(k >= 2 && k < last - 1));
      chk("R7 ce", 32'(otp_ce), 32'(k >= 3 && k < last - 2));
      chk("R4 clock phase", 32'(otp_clk), 32'(e_clk));
      if (in_words) chk("R6 address order", 32'(otp_addr), 32'(idx + j));
      if (n == 0) chk("R8 no beat on empty run", 32'(rsp_valid), 0);
      else        chk("R5 valid timing", 32'(rsp_valid), 32'(e_valid));
      if (e_valid) chk("R5 data", rsp_data, fuse_word(AW'(idx + j - 1)));
      chk("R9 busy", 32'(busy), 32'(k < last));
      chk("R7 done", 32'(req_done), 32'(k == last));
      chk("R2 no err on valid run", 32'(req_err), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    chk("R1 addr", 32'(otp_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    run_req(0, 0, 1'b0);           // R8 empty run
    run_req(5, 1, 1'b0);           // single word
    run_req(FUSES - 6, 6, 1'b0);   // exact fit at the end
    run_req(FUSES - 1, 1, 1'b0);   // last word
    run_req(FUSES - 2, 3, 1'b0);   // R2 overrun
    run_req(FUSES, 0, 1'b0);       // R2 index at limit
    run_req(FUSES + 9, 2, 1'b0);   // R2 index beyond
    run_req(100, 3, 1'b1);         // R9 start while busy
    run_req(7, 0, 1'b1);           // R9 with empty run
    repeat (3) begin
      @(negedge clk);
      chk_idle("R9 ignored start left no run");
    end

    for (int t = 0; t < 40; t++) begin
      int idx, n;
      n = $urandom_range(0, 6);
      if ($urandom_range(0, 1) == 1) idx = FUSES - $urandom_range(0, 8);
      else idx = $urandom_range(0, FUSES + 8);
      run_req(idx, n, $urandom_range(0, 3) == 0);
    end
    @(negedge clk);
    chk_idle("R9 final idle");
    report();
  end

endmodule